// File: doc/BRIEF.md
# Dual-Select Interface Clock Divider

This block makes the clock for an external parallel interface from the system clock. A 32-bit divider word holds two 16-bit divider settings, one for each of two chip selects. A dual-rate flag decides whether the chip-select input picks between the two settings or whether the lower setting always applies. A setting of zero means no division. Any other setting D is rounded up to an even ratio: the low half-period and the high half-period are each (D/2)+1 system clocks long, using integer division.

The block has two outputs. One is a registered divided clock with a 50% duty cycle. The other is a one-cycle tick that marks the last system clock of every interface period, so the bus logic can use it as a clock enable. The selection is sampled only at a period boundary. A chip-select switch or a rewrite of the divider word therefore never shortens or stretches the period that is in progress, and the divided clock never shows a runt pulse.

Top module: `xbdiv_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `if_clk` and `if_tick` are both 0.
- R2: With a selected setting of 0, `if_tick` is 1 in every cycle and `if_clk` is held at 1. The interface then runs at the system rate.
- R3: With a selected nonzero setting D, consecutive `if_tick` pulses are exactly N system clocks apart, where N = 2*((D/2)+1). For example, D=1 gives 2, D=2 and D=3 give 4, and D=4 gives 6.
- R4: Every divided period starts with `if_clk` low for N/2 cycles, followed by `if_clk` high for N/2 cycles. `if_tick` is 1 only in the final high cycle of the period.
- R5: When `dual_rate` is 1, `cs_sel`=0 selects `div_word[15:0]` and `cs_sel`=1 selects `div_word[31:16]`.
- R6: When `dual_rate` is 0, `div_word[31:16]` has no effect and both chip selects use `div_word[15:0]`.
- R7: The selection is sampled only on a tick cycle, or on the first cycle after reset, and applies from the next cycle onward. A change made on any other cycle leaves the running period unchanged.
- R8: `if_clk` falls only in the cycle that follows a tick, so no shortened high or low phase occurs.
- R9: The largest setting, 65535, gives a period of 65536 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_word | input | 32 | Two divider settings: lower half for chip select 0, upper half for chip select 1 |
| dual_rate | input | 1 | 1: `cs_sel` picks the half; 0: the lower half always applies |
| cs_sel | input | 1 | Currently active chip select (0 or 1) |
| if_clk | output | 1 | Divided interface clock, 50% duty cycle |
| if_tick | output | 1 | One-cycle pulse in the last cycle of each interface period |

## Verification
Two events can fall in the same cycle: a change of chip select or divider word, and the period boundary that samples the selection. The bench applies new settings exactly on the tick cycle, where they must take effect for the very next period. It also applies them one cycle after a tick, where the running period must first finish at its old length. A behavioural model that counts the position within the period compares both outputs on every clock, and measured gaps between ticks are checked against the ratio formula.

// File: rtl/xbdiv_pkg.sv
package xbdiv_pkg;

  // Half-period length in system clocks for a divider setting; 0 marks bypass.
  function automatic logic [31:0] half_count(input logic [31:0] d);
    if (d == 32'd0) return 32'd0;
    return (d >> 1) + 32'd1;
  endfunction

  function automatic logic is_bypass(input logic [31:0] d);
    return (d == 32'd0);
  endfunction

endpackage

// File: rtl/xbdiv_select.sv
module xbdiv_select #(
  parameter int DIV_W = 16
) (
  input  logic [2*DIV_W-1:0] div_word,
  input  logic               dual_rate,
  input  logic               cs_sel,
  output logic [DIV_W-1:0]   sel_div
);
  logic [DIV_W-1:0] lanes [2];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lanes[g] = div_word[g*DIV_W +: DIV_W];
  end

  always_comb begin
    sel_div = lanes[0];
    if (dual_rate && cs_sel) sel_div = lanes[1];
  end
endmodule

// File: rtl/xbdiv_ratio.sv
module xbdiv_ratio
  import xbdiv_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] sel_div,
  output logic [DIV_W-1:0] next_half,
  output logic             next_bypass,
  output logic [DIV_W-1:0] half_q,
  output logic             bypass_q
);
  logic [31:0] wide_div;

  assign wide_div    = 32'(sel_div);
  assign next_half   = DIV_W'(half_count(wide_div));
  assign next_bypass = is_bypass(wide_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q   <= '0;
      bypass_q <= 1'b0;
    end else if (load) begin
      half_q   <= next_half;
      bypass_q <= next_bypass;
    end
  end
endmodule

// File: rtl/xbdiv_counter.sv
module xbdiv_counter #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] load_half,
  input  logic             load_bypass,
  input  logic [DIV_W-1:0] cur_half,
  input  logic             cur_bypass,
  output logic             boundary,
  output logic             tick,
  output logic             clk_out,
  output logic             primed_q,
  output logic [DIV_W-1:0] cnt_q
);
  logic phase_q;
  logic last_cycle;

  assign last_cycle = primed_q && (cur_bypass || (phase_q && (cnt_q == '0)));
  assign boundary   = !primed_q || last_cycle;
  assign tick       = last_cycle;
  assign clk_out    = primed_q && (cur_bypass || phase_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      phase_q  <= 1'b0;
      primed_q <= 1'b0;
    end else if (boundary) begin
      primed_q <= 1'b1;
      phase_q  <= 1'b0;
      cnt_q    <= load_bypass ? '0 : load_half - DIV_W'(1);
    end else if (cnt_q == '0) begin
      phase_q <= 1'b1;
      cnt_q   <= cur_half - DIV_W'(1);
    end else begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end
endmodule

// File: rtl/xbdiv_top.sv
module xbdiv_top #(
  parameter int DIV_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*DIV_W-1:0] div_word,
  input  logic               dual_rate,
  input  logic               cs_sel,
  output logic               if_clk,
  output logic               if_tick
);
  logic [DIV_W-1:0] sel_div;
  logic [DIV_W-1:0] next_half;
  logic             next_bypass;
  logic [DIV_W-1:0] half_q;
  logic             bypass_q;
  logic             load_evt;
  logic             primed_q;
  logic [DIV_W-1:0] cnt_q;

  xbdiv_select #(.DIV_W(DIV_W)) u_sel (
    .div_word (div_word),
    .dual_rate(dual_rate),
    .cs_sel   (cs_sel),
    .sel_div  (sel_div)
  );

  xbdiv_ratio #(.DIV_W(DIV_W)) u_ratio (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_evt),
    .sel_div    (sel_div),
    .next_half  (next_half),
    .next_bypass(next_bypass),
    .half_q     (half_q),
    .bypass_q   (bypass_q)
  );

  xbdiv_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_half  (next_half),
    .load_bypass(next_bypass),
    .cur_half   (half_q),
    .cur_bypass (bypass_q),
    .boundary   (load_evt),
    .tick       (if_tick),
    .clk_out    (if_clk),
    .primed_q   (primed_q),
    .cnt_q      (cnt_q)
  );
endmodule

// File: rtl/xbdiv_checks.sv
module xbdiv_checks #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             if_clk,
  input logic             if_tick,
  input logic             load_evt,
  input logic             bypass_q,
  input logic [DIV_W-1:0] half_q,
  input logic [DIV_W-1:0] cnt_q,
  input logic             primed_q
);
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |-> (!if_clk && !if_tick));

  assert_bypass_every_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && bypass_q) |-> (if_tick && if_clk));

  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !bypass_q) |-> (cnt_q < half_q));

  assert_tick_in_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    if_tick |-> if_clk);

  assert_hold_between_bounds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> ($stable(half_q) && $stable(bypass_q)));

  assert_fall_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(if_clk) |-> $past(if_tick));
endmodule

bind xbdiv_top xbdiv_checks #(.DIV_W(DIV_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .if_clk  (if_clk),
  .if_tick (if_tick),
  .load_evt(load_evt),
  .bypass_q(bypass_q),
  .half_q  (half_q),
  .cnt_q   (cnt_q),
  .primed_q(primed_q)
);

// File: tb/xbdiv_top_tb.sv
module xbdiv_top_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] div_word = 32'd0;
  logic        dual_rate = 1'b0;
  logic        cs_sel = 1'b0;
  logic        if_clk;
  logic        if_tick;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural reference: position in period and period length
  int  m_n = 1;
  int  m_pos = 0;
  bit  m_primed = 1'b0;

  xbdiv_top u_dut (
    .clk(clk), .rst_n(rst_n), .div_word(div_word), .dual_rate(dual_rate),
    .cs_sel(cs_sel), .if_clk(if_clk), .if_tick(if_tick)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int period_of(input int d);
    if (d == 0) return 1;
    if (d % 2 == 1) return d + 1;
    return d + 2;
  endfunction

  function automatic int chosen(input logic [31:0] w, input logic dr, input logic cs);
    if (dr && cs) return int'(w[31:16]);
    return int'(w[15:0]);
  endfunction

  function automatic bit exp_tick();
    return m_primed && (m_pos == m_n - 1);
  endfunction

  function automatic bit exp_clk();
    return m_primed && ((m_n == 1) || (m_pos >= m_n / 2));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_primed = 1'b0;
      m_pos = 0;
      m_n = 1;
    end else if (!m_primed || exp_tick()) begin
      m_primed = 1'b1;
      m_n = period_of(chosen(div_word, dual_rate, cs_sel));
      m_pos = 0;
    end else begin
      m_pos++;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(if_tick == exp_tick(), "R3/R7 model tick", int'(if_tick), int'(exp_tick()));
      chk(if_clk == exp_clk(), "R4/R8 model clk", int'(if_clk), int'(exp_clk()));
    end
  end

  task automatic wait_tick();
    do @(negedge clk); while (!if_tick);
  endtask

  task automatic measure(output int gap);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!if_tick);
  endtask

  // apply a setting in a tick cycle, then measure the next period
  task automatic set_at_tick(input logic [31:0] w, input logic dr, input logic cs,
                             input int expct, input string tag);
    int gap;
    wait_tick();
    div_word = w; dual_rate = dr; cs_sel = cs;
    measure(gap);
    chk(gap == expct, tag, gap, expct);
  endtask

  initial begin
    int gap;
    int highs;
    div_word = {16'd9, 16'd1};
    repeat (3) @(negedge clk);
    chk(if_clk == 1'b0 && if_tick == 1'b0, "R1 reset outputs", int'({if_clk, if_tick}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(if_clk == 1'b0 && if_tick == 1'b0, "R1 first cycle", int'({if_clk, if_tick}), 0);

    set_at_tick({16'd9, 16'd1}, 1'b0, 1'b0, 2, "R3 D=1");
    set_at_tick({16'd9, 16'd2}, 1'b0, 1'b0, 4, "R3 D=2");
    set_at_tick({16'd9, 16'd3}, 1'b0, 1'b0, 4, "R3 D=3");
    set_at_tick({16'd9, 16'd4}, 1'b0, 1'b0, 6, "R3 D=4");

    // duty cycle over one full period of 6
    highs = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (if_clk) highs++;
    end
    chk(highs == 3, "R4 high cycles", highs, 3);

    set_at_tick(32'd0, 1'b0, 1'b0, 1, "R2 bypass gap");
    chk(if_clk == 1'b1, "R2 bypass clk high", int'(if_clk), 1);
    repeat (4) @(negedge clk);
    chk(if_tick == 1'b1 && if_clk == 1'b1, "R2 bypass steady", int'({if_clk, if_tick}), 3);

    set_at_tick({16'd6, 16'd2}, 1'b1, 1'b1, 8, "R5 cs1 upper");
    set_at_tick({16'd6, 16'd2}, 1'b1, 1'b0, 4, "R5 cs0 lower");
    set_at_tick({16'd6, 16'd2}, 1'b0, 1'b1, 4, "R6 single-rate cs1");
    set_at_tick({16'd0, 16'd2}, 1'b0, 1'b1, 4, "R6 upper zero ignored");

    // late change: one cycle after a tick, running period of 4 must finish
    wait_tick();
    @(negedge clk);
    div_word = {16'd0, 16'd10};
    measure(gap);
    chk(gap == 3, "R7 late word change", gap, 3);
    measure(gap);
    chk(gap == 12, "R7 new ratio next period", gap, 12);

    // late chip-select switch under dual rate
    set_at_tick({16'd1, 16'd10}, 1'b1, 1'b0, 12, "R5 dual cs0");
    wait_tick();
    repeat (2) @(negedge clk);
    cs_sel = 1'b1;
    measure(gap);
    chk(gap == 10, "R7 late cs switch", gap, 10);
    measure(gap);
    chk(gap == 2, "R7 cs1 after boundary", gap, 2);

    set_at_tick({16'd1, 16'd65535}, 1'b0, 1'b0, 65536, "R9 max setting");
    set_at_tick({16'd1, 16'd5}, 1'b0, 1'b0, 6, "R9 return from max");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule